// File: doc/BRIEF.md
# Two-Stage Conditioned-Operand ALU

This block is a purely combinational arithmetic logic unit for a narrow datapath (4 bits by default). It works in two cascaded stages. The first stage conditions operand B: it leaves it alone, flips every bit, or forms its two's complement negation. The second stage then combines the conditioned value with operand A by a bitwise AND or a ripple-carry addition, or forwards the conditioned value unchanged.

The operation is not picked by one opcode. Two independent control pairs select it. One pair (invert, negate) drives the conditioning stage. The other pair (pass, add) drives the combining stage. Subtraction A minus B is therefore the combination invert=1, negate=1, pass=0, add=1. A carry-out accompanies the result; it is meaningful only when the adder is selected.

Top module: `alu2_top`

## Requirements
- R1: With inv_en_i = 0 the conditioned operand equals opb_i, whatever neg_en_i holds.
- R2: With inv_en_i = 1 and neg_en_i = 0 the conditioned operand is the bitwise inverse of opb_i.
- R3: With inv_en_i = 1 and neg_en_i = 1 the conditioned operand is (2^W - opb_i) mod 2^W; opb_i = 0 gives 0 and opb_i = 2^(W-1) gives itself.
- R4: With thru_en_i = 1, res_o equals the conditioned operand, whatever sum_en_i holds.
- R5: With thru_en_i = 0 and sum_en_i = 0, res_o is opa_i AND the conditioned operand.
- R6: With thru_en_i = 0 and sum_en_i = 1, {cout_o, res_o} is the (W+1)-bit sum of opa_i and the conditioned operand.
- R7: With all four controls set except thru_en_i, res_o is (opa_i - opb_i) mod 2^W, and cout_o is 1 exactly when opb_i is nonzero and opa_i >= opb_i.
- R8: cout_o is 0 whenever the adder is not selected (AND mode or pass mode).
- R9: The block holds no state: res_o and cout_o follow an input change within the same time step, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | W | Operand A, fed to the combining stage only |
| opb_i | input | W | Operand B, conditioned by the first stage |
| inv_en_i | input | 1 | Enables inversion of operand B |
| neg_en_i | input | 1 | With inv_en_i, turns inversion into negation |
| thru_en_i | input | 1 | Forwards the conditioned operand, overriding sum_en_i |
| sum_en_i | input | 1 | Selects addition instead of AND when not forwarding |
| res_o | output | W | Result |
| cout_o | output | 1 | Adder carry-out, 0 outside add mode |

## Verification
The bench builds the block with the default width W = 4. At that width every operand pair can be swept: 256 pairs under all 16 control combinations. This reaches the edges of the conditioning and carry logic. It covers negation of zero and of the most negative value, full carry propagation such as 15 + 1, and subtraction of equal operands. Random vectors from a fixed seed and a few directed vectors that change inputs without a clock edge complete the run.

// File: rtl/alu2_pkg.sv
`timescale 1ns/1ps
package alu2_pkg;

    typedef enum logic [1:0] {
        COND_KEEP = 2'd0,
        COND_ONES = 2'd1,
        COND_TWOS = 2'd2
    } cond_mode_e;

    typedef enum logic [1:0] {
        COMB_AND  = 2'd0,
        COMB_ADD  = 2'd1,
        COMB_PASS = 2'd2
    } comb_mode_e;

    typedef struct packed {
        logic inv;
        logic neg;
        logic thru;
        logic sum;
    } alu2_ctrl_t;

    function automatic cond_mode_e decode_cond(input alu2_ctrl_t c);
        if (!c.inv)     return COND_KEEP;
        else if (!c.neg) return COND_ONES;
        else            return COND_TWOS;
    endfunction

    function automatic comb_mode_e decode_comb(input alu2_ctrl_t c);
        if (c.thru)     return COMB_PASS;
        else if (c.sum) return COMB_ADD;
        else            return COMB_AND;
    endfunction

endpackage

// File: rtl/alu2_cond.sv
`timescale 1ns/1ps
module alu2_cond
    import alu2_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opnd_i,
    input  cond_mode_e   mode_i,
    output logic [W-1:0] cond_o
);

    logic [W-1:0] flipped;
    logic [W-1:0] incr;
    logic [W-1:0] inc_c;

    assign flipped  = ~opnd_i;
    assign inc_c[0] = 1'b1;

    // Half-adder increment chain turns the inverse into the negation.
    for (genvar i = 0; i < W; i++) begin : g_inc
        assign incr[i] = flipped[i] ^ inc_c[i];
        if (i < W - 1) begin : g_carry
            assign inc_c[i+1] = flipped[i] & inc_c[i];
        end
    end

    always_comb begin
        case (mode_i)
            COND_ONES: cond_o = flipped;
            COND_TWOS: cond_o = incr;
            default:   cond_o = opnd_i;
        endcase
    end

endmodule

// File: rtl/alu2_ripple.sv
`timescale 1ns/1ps
module alu2_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    logic [W:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic hx;
        assign hx      = x_i[i] ^ y_i[i];
        assign s_o[i]  = hx ^ cy[i];
        assign cy[i+1] = (x_i[i] & y_i[i]) | (hx & cy[i]);
    end

    assign c_o = cy[W];

endmodule

// File: rtl/alu2_comb.sv
`timescale 1ns/1ps
module alu2_comb
    import alu2_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] x_i,
    input  comb_mode_e   mode_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    logic [W-1:0] add_s;
    logic         add_c;

    alu2_ripple #(.W(W)) u_add (
        .x_i (a_i),
        .y_i (x_i),
        .s_o (add_s),
        .c_o (add_c)
    );

    always_comb begin
        res_o  = a_i & x_i;
        cout_o = 1'b0;
        case (mode_i)
            COMB_ADD: begin
                res_o  = add_s;
                cout_o = add_c;
            end
            COMB_PASS: res_o = x_i;
            default:   ;
        endcase
    end

endmodule

// File: rtl/alu2_top.sv
`timescale 1ns/1ps
module alu2_top
    import alu2_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         inv_en_i,
    input  logic         neg_en_i,
    input  logic         thru_en_i,
    input  logic         sum_en_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    localparam int WE = W + 1;

    alu2_ctrl_t ctrl;
    cond_mode_e cmode;
    comb_mode_e kmode;
    logic [W-1:0] cond_b;

    assign ctrl  = '{inv: inv_en_i, neg: neg_en_i, thru: thru_en_i, sum: sum_en_i};
    assign cmode = decode_cond(ctrl);
    assign kmode = decode_comb(ctrl);

    alu2_cond #(.W(W)) u_cond (
        .opnd_i (opb_i),
        .mode_i (cmode),
        .cond_o (cond_b)
    );

    alu2_comb #(.W(W)) u_comb (
        .a_i    (opa_i),
        .x_i    (cond_b),
        .mode_i (kmode),
        .res_o  (res_o),
        .cout_o (cout_o)
    );

    // Cross-stage checks on the settled combinational values.
    always_comb begin
        if (!inv_en_i) begin
            assert_cond_keep_R1: assert (cond_b == opb_i)
                else $error("conditioned operand differs from B");
        end
        if (inv_en_i && !neg_en_i) begin
            assert_cond_ones_R2: assert ((cond_b ^ opb_i) == {W{1'b1}})
                else $error("conditioned operand is not the inverse");
        end
        if (inv_en_i && neg_en_i) begin
            assert_cond_twos_R3: assert (W'(cond_b + opb_i) == '0)
                else $error("conditioned operand is not the negation");
        end
        if (thru_en_i) begin
            assert_pass_R4: assert (res_o == cond_b)
                else $error("pass mode result mismatch");
        end
        if (!thru_en_i && !sum_en_i) begin
            assert_and_R5: assert (res_o == (opa_i & cond_b))
                else $error("AND mode result mismatch");
        end
        if (!thru_en_i && sum_en_i) begin
            assert_add_R6: assert ({cout_o, res_o} == (WE'(opa_i) + WE'(cond_b)))
                else $error("add mode result mismatch");
        end
        if (thru_en_i || !sum_en_i) begin
            assert_cout_zero_R8: assert (!cout_o)
                else $error("carry set outside add mode");
        end
    end

endmodule

// File: tb/sim_alu2_top.sv
`timescale 1ns/1ps
module sim_alu2_top;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] opa, opb;
    logic inv, neg, thru, sum;
    logic [W-1:0] res;
    logic cout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    alu2_top #(.W(W)) u0 (
        .opa_i     (opa),
        .opb_i     (opb),
        .inv_en_i  (inv),
        .neg_en_i  (neg),
        .thru_en_i (thru),
        .sum_en_i  (sum),
        .res_o     (res),
        .cout_o    (cout)
    );

    // Reference model written from the requirements with integer arithmetic.
    function automatic int model(input int a, input int b, input bit fi,
                                 input bit fn, input bit fp, input bit fs);
        int c;
        int t;
        if (!fi)      c = b;                 // R1
        else if (!fn) c = (N - 1) - b;       // R2
        else          c = (N - b) % N;       // R3
        if (fp) return c;                    // R4, carry 0 (R8)
        if (!fs) return a & c;               // R5, carry 0 (R8)
        t = a + c;                           // R6 / R7
        return t;
    endfunction

    function automatic string tag_of(input bit fi, input bit fn,
                                     input bit fp, input bit fs);
        if (fp)        return "R4";
        if (!fs)       return "R5";
        if (fi && fn)  return "R7";
        return "R6";
    endfunction

    task automatic check(input string rq, input int expv);
        int got;
        got = {27'd0, cout, res};
        n_chk++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: a=%0d b=%0d ctl=%b%b%b%b got cout=%0d res=%0d exp cout=%0d res=%0d",
                     rq, opa, opb, inv, neg, thru, sum,
                     got / N, got % N, expv / N, expv % N);
        end
    endtask

    task automatic apply(input int a, input int b, input bit fi, input bit fn,
                         input bit fp, input bit fs, input string rq);
        @(posedge clk);
        opa = W'(a); opb = W'(b);
        inv = fi; neg = fn; thru = fp; sum = fs;
        #1;
        check(rq, model(a, b, fi, fn, fp, fs));
    endtask

    initial begin
        opa = '0; opb = '0; inv = 0; neg = 0; thru = 0; sum = 0;
        void'($urandom(32'd20240917));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // Initial state: all inputs zero gives a zero AND result
        check("R5", 0);

        // Directed corner cases
        apply(0, 5, 0, 1, 1, 1, "R1");      // neg ignored without invert, add ignored
        apply(0, 5, 1, 0, 1, 0, "R2");      // inverse 10
        apply(0, 0, 1, 1, 1, 0, "R3");      // -0 = 0
        apply(0, 8, 1, 1, 1, 0, "R3");      // -8 = 8
        apply(15, 1, 0, 0, 0, 1, "R6");     // full carry ripple: 0, carry 1
        apply(6, 6, 1, 1, 0, 1, "R7");      // equal operands: 0, carry 1
        apply(3, 0, 1, 1, 0, 1, "R7");      // minus zero: 3, carry 0
        apply(2, 9, 1, 1, 0, 1, "R7");      // borrow: 9, carry 0
        apply(15, 15, 0, 0, 0, 0, "R8");    // AND mode: carry must stay 0
        apply(15, 15, 0, 0, 1, 1, "R8");    // pass mode: carry must stay 0

        // R9: change inputs between edges and observe without any edge
        @(negedge clk);
        opa = 4'd7; opb = 4'd9; inv = 0; neg = 0; thru = 0; sum = 1;
        #0.5;
        check("R9", model(7, 9, 0, 0, 0, 1));
        opb = 4'd1;
        #0.5;
        check("R9", model(7, 1, 0, 0, 0, 1));

        // Exhaustive sweep: every control combination and operand pair
        for (int k = 0; k < 16; k++) begin
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    apply(a, b, k[3], k[2], k[1], k[0],
                          tag_of(k[3], k[2], k[1], k[0]));
                end
            end
        end

        // Constrained random: add and subtract weighted higher
        for (int r = 0; r < 2000; r++) begin
            int a;
            int b;
            bit fi, fn, fp, fs;
            a  = int'($urandom_range(N - 1, 0));
            b  = int'($urandom_range(N - 1, 0));
            fi = 1'($urandom_range(1, 0));
            fn = 1'($urandom_range(1, 0));
            fp = ($urandom_range(3, 0) == 0);
            fs = ($urandom_range(3, 0) != 0);
            apply(a, b, fi, fn, fp, fs, tag_of(fi, fn, fp, fs));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule